// File: doc/BRIEF.md
# Video-Mode Line Token Sequencer

This block decides which packet tokens a display serial host sends, and in what order, while it drives a panel in video mode. It walks through each frame line by line. For every line it emits tokens on a valid/ready stream: sync starts, sync ends, blanking runs with a byte length, pixel payload with a byte length, null filler with a byte length, and end-of-transmission markers. Each token carries the frame's virtual channel. Downstream logic turns the tokens into packets, adds ECC and CRC, spreads them across lanes and drives the PHY.

The configuration inputs are sampled in the single idle cycle that comes before each frame. The inputs are:

- a fill-mode code;
- skip bits for the sync-width, back-porch and front-porch regions;
- a sync-end enable for blanking lines;
- an auto vertical count bit;
- an EoT disable;
- the channel number;
- a pixel format code;
- vertical line counts;
- horizontal byte lengths;
- the active width in pixels;
- the active-region time in byte-clock units.

If the fill-mode code is not a video code, the block stays idle. When the consumer holds ready low, the current token stays on the outputs and no state is lost.

Top module: `vid_line_seq`

## Requirements
- R1: The fill-mode code `cfg_mode` selects the line layout: 0 = non-burst with sync events, 1 = burst, 2 = non-burst with sync pulses. Any other code (for example 4, command mode) keeps `tok_valid` low.
- R2: In normal counting, a frame is `cfg_vsa` sync lines, then `cfg_vbp` back-porch lines, then `cfg_vact` active lines, then `cfg_vfp` front-porch lines. Every line opens with one start token whose `tok_kind` is one of three codes. Line 0 opens with VSS (0). In mode 2 with `cfg_vsa` > 0, line `cfg_vsa` opens with VSE (1). Every other line opens with HSS (2).
- R3: A non-active line carries only its start token. An HSE (3) follows the start token only when `cfg_sync_end_en` is 1. The EoT rule of R8 then applies.
- R4: An active line emits its regions in this fixed order:
  - the start token;
  - in mode 2 only, sync-width blanking (4) of length `cfg_hsa`, then HSE (3);
  - back-porch blanking (4) of length `cfg_hbp`;
  - pixel payload (5);
  - null filler (6);
  - front-porch blanking (4) of length `cfg_hfp`;
  - EoT (7).
- R5: Setting `cfg_skip_hsa`, `cfg_skip_hbp` or `cfg_skip_hfp` removes the matching blanking token. A blanking region whose length is zero is also left out.
- R6: The payload length equals ceil(width × bpp / 8). The bpp comes from the format code: 0→3, 1→8, 2→12, 3→16, 4→16, 5→18, 6→24, 7→24. A zero-byte payload emits no pixel token.
- R7: In modes 0 and 2, a null token of length `cfg_act_time` minus the payload follows the payload, but only when that difference is positive. Mode 1 never emits a null token.
- R8: Every line ends with an EoT token (7) unless `cfg_eot_off` is 1.
- R9: With `cfg_auto_vcnt` set, a frame is `cfg_vact` active lines followed by `cfg_vfp` front-porch lines. The first active line opens with VSS, and no VSE is sent.
- R10: Every token carries on `tok_vc` the channel that was sampled for its frame.
- R11: Configuration is captured in the idle cycle before a frame. `tok_valid` is low for exactly that one cycle after the last token of a frame. Input changes during a frame take effect only in the next frame.
- R12: While `tok_valid` is high and `tok_ready` is low, the token outputs hold their values and nothing is skipped.
- R13: While `rst_n` is low, `tok_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 3 | Fill-mode code |
| cfg_sync_end_en | input | 1 | Add HSE on non-active lines |
| cfg_skip_hsa | input | 1 | Drop sync-width blanking |
| cfg_skip_hbp | input | 1 | Drop back-porch blanking |
| cfg_skip_hfp | input | 1 | Drop front-porch blanking |
| cfg_auto_vcnt | input | 1 | Count active and front-porch lines only |
| cfg_eot_off | input | 1 | Suppress EoT tokens |
| cfg_vc | input | 2 | Virtual channel |
| cfg_pix_fmt | input | 3 | Pixel format code |
| cfg_vsa | input | LINE_W | Sync line count |
| cfg_vbp | input | LINE_W | Back-porch line count |
| cfg_vact | input | LINE_W | Active line count (at least 1) |
| cfg_vfp | input | LINE_W | Front-porch line count |
| cfg_hsa | input | LEN_W | Sync-width blanking bytes |
| cfg_hbp | input | LEN_W | Back-porch blanking bytes |
| cfg_hfp | input | LEN_W | Front-porch blanking bytes |
| cfg_width | input | PIX_W | Active pixels per line |
| cfg_act_time | input | LEN_W | Active-region time in byte clocks |
| tok_valid | output | 1 | Token present |
| tok_ready | input | 1 | Consumer accepts token |
| tok_kind | output | 3 | Token code |
| tok_len | output | LEN_W | Byte length of blanking, payload or null tokens, else 0 |
| tok_vc | output | 2 | Channel of the token |

## Verification
The bench builds the block with LINE_W = 4, LEN_W = 10 and PIX_W = 6. With these values a frame is only a handful of lines, so the bench can afford to run whole frames for every combination of fill mode and pixel format, and for every skip-bit pattern under both counting modes. Widths up to 12 pixels make the rounding in the payload formula show up for each format. The active-region time is chosen so that some lines get null filler and others do not. Ready is throttled by a pseudo-random pattern, so stalls land on every kind of token.

// File: rtl/vls_pkg.sv
// Shared types for the video line token sequencer.
// Token codes and step numbering are visible to neighbours, so their values are fixed.
package vls_pkg;

    typedef enum logic [2:0] {
        TK_VSS   = 3'd0,
        TK_VSE   = 3'd1,
        TK_HSS   = 3'd2,
        TK_HSE   = 3'd3,
        TK_BLANK = 3'd4,
        TK_PIXEL = 3'd5,
        TK_NULL  = 3'd6,
        TK_EOT   = 3'd7
    } tok_kind_e;

    // Position of each region inside a line; the order is the emission order.
    typedef enum logic [2:0] {
        ST_LEAD    = 3'd0,
        ST_SYNCW   = 3'd1,
        ST_SYNCEND = 3'd2,
        ST_BACK    = 3'd3,
        ST_PAY     = 3'd4,
        ST_FILL    = 3'd5,
        ST_FRONT   = 3'd6,
        ST_TAIL    = 3'd7
    } step_e;

    typedef enum logic [1:0] {
        LC_VSYNC,
        LC_VPORCH,
        LC_ACTIVE,
        LC_VFRONT
    } line_cls_e;

    localparam logic [2:0] MODE_EVENTS = 3'd0;
    localparam logic [2:0] MODE_BURST  = 3'd1;
    localparam logic [2:0] MODE_PULSE  = 3'd2;

    typedef struct packed {
        logic [2:0] mode;
        logic       sync_end_en;
        logic       skip_hsa;
        logic       skip_hbp;
        logic       skip_hfp;
        logic       auto_vcnt;
        logic       eot_off;
        logic [1:0] vc;
        logic [2:0] fmt;
    } flags_t;

    // Bits per pixel for each format code.
    function automatic logic [4:0] fmt_bpp(input logic [2:0] f);
        case (f)
            3'd0:    return 5'd3;
            3'd1:    return 5'd8;
            3'd2:    return 5'd12;
            3'd3:    return 5'd16;
            3'd4:    return 5'd16;
            3'd5:    return 5'd18;
            default: return 5'd24;
        endcase
    endfunction

endpackage

// File: rtl/vls_payload_calc.sv
// Payload byte count for one active line.
// Computes ceil(width * bpp / 8). Assumes the result fits in LEN_W bits.
module vls_payload_calc #(
    parameter int PIX_W = 12,
    parameter int LEN_W = 16
) (
    input  logic [2:0]       fmt,
    input  logic [PIX_W-1:0] width,
    output logic [LEN_W-1:0] bytes
);
    import vls_pkg::*;

    localparam int BIT_W = PIX_W + 6;

    logic [BIT_W-1:0] bits;
    logic [BIT_W-1:0] rounded;

    // Multiply the width by bpp, then round up to whole bytes.
    always_comb begin
        bits    = BIT_W'(width) * BIT_W'(fmt_bpp(fmt));
        rounded = bits + BIT_W'(7);
        bytes   = LEN_W'(rounded >> 3);
    end
endmodule

// File: rtl/vls_vtimer.sv
// Vertical line counter. Classifies the current line of the frame and flags the
// first line, the line that carries the vertical sync end, and the last line.
// Assumes the counts stay stable during a frame and vact >= 1.
module vls_vtimer #(
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              advance,
    input  logic              auto_vcnt,
    input  logic [LINE_W-1:0] vsa,
    input  logic [LINE_W-1:0] vbp,
    input  logic [LINE_W-1:0] vact,
    input  logic [LINE_W-1:0] vfp,
    output vls_pkg::line_cls_e line_cls,
    output logic              first_line,
    output logic              vse_line,
    output logic              last_line
);
    import vls_pkg::*;

    localparam int SUM_W = LINE_W + 2;

    logic [SUM_W-1:0] line_q;
    logic [SUM_W-1:0] a_end, b_end, c_end, total;

    // Region boundaries; auto counting folds sync and back porch away.
    always_comb begin
        a_end = auto_vcnt ? '0 : SUM_W'(vsa);
        b_end = auto_vcnt ? '0 : SUM_W'(vsa) + SUM_W'(vbp);
        c_end = b_end + SUM_W'(vact);
        total = c_end + SUM_W'(vfp);
    end

    // Classify the current line and flag its position.
    always_comb begin
        if (line_q < a_end)      line_cls = LC_VSYNC;
        else if (line_q < b_end) line_cls = LC_VPORCH;
        else if (line_q < c_end) line_cls = LC_ACTIVE;
        else                     line_cls = LC_VFRONT;
        first_line = (line_q == '0);
        vse_line   = !auto_vcnt && (vsa != '0) && (line_q == a_end);
        last_line  = (line_q == total - SUM_W'(1));
    end

    // Advance the line counter at each line end and wrap at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n)       line_q <= '0;
        else if (restart) line_q <= '0;
        else if (advance) line_q <= last_line ? '0 : line_q + SUM_W'(1);
    end

    // R2
    line_within_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> line_q < total);
endmodule

// File: rtl/vls_hstep.sv
// Horizontal stepper. Moves through the eight region slots of a line and skips
// the slots that are absent. Slot 0 is always present.
module vls_hstep (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fire,
    input  logic [7:0]     present,
    output vls_pkg::step_e step,
    output logic           line_done
);
    import vls_pkg::*;

    logic [2:0] step_q;
    logic [2:0] nxt;

    // Find the lowest present slot above the current one.
    always_comb begin
        nxt       = step_q;
        line_done = 1'b1;
        for (int i = 7; i >= 1; i--) begin
            if ((3'(i) > step_q) && present[i]) begin
                nxt       = 3'(i);
                line_done = 1'b0;
            end
        end
    end

    // Move to the next slot on each accepted token; return to slot 0 at line end.
    always_ff @(posedge clk) begin
        if (!rst_n)    step_q <= '0;
        else if (fire) step_q <= line_done ? '0 : nxt;
    end

    assign step = step_e'(step_q);

    // R4
    step_rises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire && !line_done |=> step_q > $past(step_q));
endmodule

// File: rtl/vid_line_seq.sv
// Video-mode line token sequencer (top). Captures the configuration in an idle
// cycle, then emits the tokens of one frame on a valid/ready stream.
// Assumes cfg_vact >= 1. The outputs are a function of state only, so they hold
// while the stream is stalled.
module vid_line_seq #(
    parameter int LINE_W = 12,
    parameter int LEN_W  = 16,
    parameter int PIX_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_mode,
    input  logic              cfg_sync_end_en,
    input  logic              cfg_skip_hsa,
    input  logic              cfg_skip_hbp,
    input  logic              cfg_skip_hfp,
    input  logic              cfg_auto_vcnt,
    input  logic              cfg_eot_off,
    input  logic [1:0]        cfg_vc,
    input  logic [2:0]        cfg_pix_fmt,
    input  logic [LINE_W-1:0] cfg_vsa,
    input  logic [LINE_W-1:0] cfg_vbp,
    input  logic [LINE_W-1:0] cfg_vact,
    input  logic [LINE_W-1:0] cfg_vfp,
    input  logic [LEN_W-1:0]  cfg_hsa,
    input  logic [LEN_W-1:0]  cfg_hbp,
    input  logic [LEN_W-1:0]  cfg_hfp,
    input  logic [PIX_W-1:0]  cfg_width,
    input  logic [LEN_W-1:0]  cfg_act_time,
    output logic              tok_valid,
    input  logic              tok_ready,
    output logic [2:0]        tok_kind,
    output logic [LEN_W-1:0]  tok_len,
    output logic [1:0]        tok_vc
);
    import vls_pkg::*;

    flags_t            flags_q;
    logic [LINE_W-1:0] vsa_q, vbp_q, vact_q, vfp_q;
    logic [LEN_W-1:0]  hsa_q, hbp_q, hfp_q, act_q;
    logic [PIX_W-1:0]  width_q;
    logic              running;

    logic              mode_ok, load, fire, frame_end;
    logic              is_act, pulse, nonburst;
    logic [7:0]        present;
    logic [LEN_W-1:0]  pay_bytes;
    line_cls_e         line_cls;
    logic              first_line, vse_line, last_line, line_done;
    step_e             step;
    tok_kind_e         kind;

    assign mode_ok   = (cfg_mode <= MODE_PULSE);
    assign load      = !running && mode_ok;
    assign fire      = running && tok_ready;
    assign frame_end = fire && line_done && last_line;

    // Capture the frame configuration in the idle cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            vsa_q   <= '0; vbp_q <= '0; vact_q <= '0; vfp_q <= '0;
            hsa_q   <= '0; hbp_q <= '0; hfp_q  <= '0; act_q <= '0;
            width_q <= '0;
        end else if (load) begin
            flags_q <= '{mode: cfg_mode, sync_end_en: cfg_sync_end_en,
                         skip_hsa: cfg_skip_hsa, skip_hbp: cfg_skip_hbp,
                         skip_hfp: cfg_skip_hfp, auto_vcnt: cfg_auto_vcnt,
                         eot_off: cfg_eot_off, vc: cfg_vc, fmt: cfg_pix_fmt};
            vsa_q   <= cfg_vsa;  vbp_q <= cfg_vbp;  vact_q <= cfg_vact; vfp_q <= cfg_vfp;
            hsa_q   <= cfg_hsa;  hbp_q <= cfg_hbp;  hfp_q  <= cfg_hfp;  act_q <= cfg_act_time;
            width_q <= cfg_width;
        end
    end

    // Frame activity: set on load, cleared after the last token of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n)         running <= 1'b0;
        else if (load)      running <= 1'b1;
        else if (frame_end) running <= 1'b0;
    end

    vls_payload_calc #(.PIX_W(PIX_W), .LEN_W(LEN_W)) u_pay (
        .fmt   (flags_q.fmt),
        .width (width_q),
        .bytes (pay_bytes)
    );

    vls_vtimer #(.LINE_W(LINE_W)) u_vt (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (load),
        .advance    (fire && line_done),
        .auto_vcnt  (flags_q.auto_vcnt),
        .vsa        (vsa_q),
        .vbp        (vbp_q),
        .vact       (vact_q),
        .vfp        (vfp_q),
        .line_cls   (line_cls),
        .first_line (first_line),
        .vse_line   (vse_line),
        .last_line  (last_line)
    );

    // Decide which region slots the current line contains.
    always_comb begin
        is_act   = (line_cls == LC_ACTIVE);
        pulse    = (flags_q.mode == MODE_PULSE);
        nonburst = (flags_q.mode != MODE_BURST);
        present[ST_LEAD]    = 1'b1;
        present[ST_SYNCW]   = is_act && pulse && !flags_q.skip_hsa && (hsa_q != '0);
        present[ST_SYNCEND] = is_act ? pulse : flags_q.sync_end_en;
        present[ST_BACK]    = is_act && !flags_q.skip_hbp && (hbp_q != '0);
        present[ST_PAY]     = is_act && (pay_bytes != '0);
        present[ST_FILL]    = is_act && nonburst && (act_q > pay_bytes);
        present[ST_FRONT]   = is_act && !flags_q.skip_hfp && (hfp_q != '0);
        present[ST_TAIL]    = !flags_q.eot_off;
    end

    vls_hstep u_hs (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .present   (present),
        .step      (step),
        .line_done (line_done)
    );

    // Map the current slot to a token code and length.
    always_comb begin
        kind    = TK_EOT;
        tok_len = '0;
        case (step)
            ST_LEAD:    kind = first_line ? TK_VSS : ((vse_line && pulse) ? TK_VSE : TK_HSS);
            ST_SYNCW:   begin kind = TK_BLANK; tok_len = hsa_q; end
            ST_SYNCEND: kind = TK_HSE;
            ST_BACK:    begin kind = TK_BLANK; tok_len = hbp_q; end
            ST_PAY:     begin kind = TK_PIXEL; tok_len = pay_bytes; end
            ST_FILL:    begin kind = TK_NULL;  tok_len = act_q - pay_bytes; end
            ST_FRONT:   begin kind = TK_BLANK; tok_len = hfp_q; end
            default:    kind = TK_EOT;
        endcase
    end

    assign tok_valid = running;
    assign tok_kind  = kind;
    assign tok_vc    = flags_q.vc;

    // R12
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid && !tok_ready |=> tok_valid && $stable(tok_kind) && $stable(tok_len) && $stable(tok_vc));

    // R10
    vc_frame_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid && $past(tok_valid) |-> tok_vc == $past(tok_vc));

    // R11
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running && $past(running) |-> $stable(flags_q) && $stable(act_q) && $stable(width_q));

    // R7
    burst_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid && tok_kind == TK_NULL |-> flags_q.mode != MODE_BURST);
endmodule

// File: tb/vid_line_seq_test.sv
// Self-checking bench: builds each frame's expected token list arithmetically
// and compares it against the stream under a pseudo-random ready pattern.
module vid_line_seq_test;
    localparam int LW = 4;
    localparam int NW = 10;
    localparam int PW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    cfg_mode = 3'd0;
    logic          cfg_sync_end_en = 1'b0, cfg_skip_hsa = 1'b0, cfg_skip_hbp = 1'b0;
    logic          cfg_skip_hfp = 1'b0, cfg_auto_vcnt = 1'b0, cfg_eot_off = 1'b0;
    logic [1:0]    cfg_vc = 2'd0;
    logic [2:0]    cfg_pix_fmt = 3'd0;
    logic [LW-1:0] cfg_vsa = '0, cfg_vbp = '0, cfg_vact = '0, cfg_vfp = '0;
    logic [NW-1:0] cfg_hsa = '0, cfg_hbp = '0, cfg_hfp = '0, cfg_act_time = '0;
    logic [PW-1:0] cfg_width = '0;
    logic          tok_valid, tok_ready = 1'b0;
    logic [2:0]    tok_kind;
    logic [NW-1:0] tok_len;
    logic [1:0]    tok_vc;

    int n_chk = 0, n_err = 0;
    logic [15:0] lfsr = 16'hACE1;

    int b_mode, b_se, b_shsa, b_shbp, b_shfp, b_auto, b_eot_off, b_vc, b_fmt;
    int b_vsa, b_vbp, b_vact, b_vfp, b_hsa, b_hbp, b_hfp, b_w, b_act;

    int    ek[$];
    int    el[$];
    string et[$];

    always #5 clk = ~clk;

    vid_line_seq #(.LINE_W(LW), .LEN_W(NW), .PIX_W(PW)) uut (.*);

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic apply();
        cfg_mode = 3'(b_mode); cfg_sync_end_en = b_se[0]; cfg_skip_hsa = b_shsa[0];
        cfg_skip_hbp = b_shbp[0]; cfg_skip_hfp = b_shfp[0]; cfg_auto_vcnt = b_auto[0];
        cfg_eot_off = b_eot_off[0]; cfg_vc = 2'(b_vc); cfg_pix_fmt = 3'(b_fmt);
        cfg_vsa = LW'(b_vsa); cfg_vbp = LW'(b_vbp); cfg_vact = LW'(b_vact); cfg_vfp = LW'(b_vfp);
        cfg_hsa = NW'(b_hsa); cfg_hbp = NW'(b_hbp); cfg_hfp = NW'(b_hfp);
        cfg_width = PW'(b_w); cfg_act_time = NW'(b_act);
    endtask

    function automatic int bpp_of(input int f);
        case (f)
            0: return 3;  1: return 8;  2: return 12; 3: return 16;
            4: return 16; 5: return 18; default: return 24;
        endcase
    endfunction

    function automatic void push(input int k, input int l, input string t);
        ek.push_back(k); el.push_back(l); et.push_back(t);
    endfunction

    // Expected token list for one frame, from the requirements.
    function automatic void build();
        int nb, a, b, c, tot, st;
        bit pulse, nonburst, act;
        ek.delete(); el.delete(); et.delete();
        nb = (b_w * bpp_of(b_fmt) + 7) / 8;
        pulse = (b_mode == 2);
        nonburst = (b_mode != 1);
        a = b_auto ? 0 : b_vsa;
        b = b_auto ? 0 : b_vsa + b_vbp;
        c = b + b_vact;
        tot = c + b_vfp;
        for (int l = 0; l < tot; l++) begin
            act = (l >= b) && (l < c);
            st = (l == 0) ? 0 : ((pulse && !b_auto && b_vsa != 0 && l == a) ? 1 : 2);
            push(st, 0, b_auto ? "R9" : "R2");
            if (act) begin
                if (pulse && !b_shsa && b_hsa != 0) push(4, b_hsa, "R5");
                if (pulse) push(3, 0, "R4");
                if (!b_shbp && b_hbp != 0) push(4, b_hbp, "R5");
                if (nb != 0) push(5, nb, "R6");
                if (nonburst && b_act > nb) push(6, b_act - nb, "R7");
                if (!b_shfp && b_hfp != 0) push(4, b_hfp, "R5");
            end else if (b_se) begin
                push(3, 0, "R3");
            end
            if (!b_eot_off) push(7, 0, "R8");
        end
    endfunction

    // Run one frame under throttled ready; optionally alter inputs mid-frame.
    task automatic run_frame(input bit midchange);
        int idx = 0;
        bit stalled = 0;
        int fvc = b_vc;
        build();
        while (idx < ek.size()) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            tok_ready = lfsr[0] | lfsr[1];
            #1;
            if (tok_valid) begin
                chk(tok_kind == 3'(ek[idx]), stalled ? "R12" : et[idx], "kind", int'(tok_kind), ek[idx]);
                chk(tok_len == NW'(el[idx]), stalled ? "R12" : et[idx], "len", int'(tok_len), el[idx]);
                chk(tok_vc == 2'(fvc), "R10", "vc", int'(tok_vc), fvc);
                if (tok_ready) begin
                    idx++;
                    stalled = 0;
                    if (midchange && idx == 1) begin
                        cfg_vc = 2'(fvc + 1);
                        cfg_hbp = NW'(b_hbp + 3);
                    end
                end else begin
                    stalled = 1;
                end
            end
        end
        @(negedge clk);
        #1;
        chk(!tok_valid, "R11", "idle cycle after frame", int'(tok_valid), 0);
    endtask

    task automatic base_cfg();
        b_mode = 2; b_se = 0; b_shsa = 0; b_shbp = 0; b_shfp = 0; b_auto = 0; b_eot_off = 0;
        b_vc = 1; b_fmt = 7; b_vsa = 1; b_vbp = 1; b_vact = 2; b_vfp = 1;
        b_hsa = 3; b_hbp = 2; b_hfp = 4; b_w = 6; b_act = 30;
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        base_cfg();
        apply();
        // R13: reset holds the stream quiet
        repeat (3) begin
            @(negedge clk); #1;
            chk(!tok_valid, "R13", "valid in reset", int'(tok_valid), 0);
        end
        rst_n = 1'b1;
        run_frame(0);

        // Mode and format sweep (R1, R4, R6, R7, R8)
        for (int m = 0; m < 3; m++) begin
            for (int f = 0; f < 8; f++) begin
                base_cfg();
                b_mode = m; b_fmt = f; b_w = 5 + f; b_se = f & 1;
                b_eot_off = (f == 3); b_vc = f & 3;
                apply();
                run_frame(0);
            end
        end

        // Skip bits, zero lengths and auto counting (R5, R9, R3)
        for (int m = 0; m < 3; m += 2) begin
            for (int s = 0; s < 8; s++) begin
                for (int au = 0; au < 2; au++) begin
                    base_cfg();
                    b_mode = m; b_shsa = s & 1; b_shbp = (s >> 1) & 1; b_shfp = (s >> 2) & 1;
                    b_auto = au; b_vsa = 2; b_vfp = 2; b_se = au;
                    b_hsa = (s == 2) ? 0 : 3; b_hbp = (s == 4) ? 0 : 2; b_hfp = (s == 1) ? 0 : 4;
                    b_fmt = s; b_w = 3 + s;
                    apply();
                    run_frame(0);
                end
            end
        end

        // R2: no sync lines, so no VSE; R6: zero width gives no payload
        base_cfg(); b_vsa = 0; b_vbp = 2; b_w = 0;
        apply(); run_frame(0);

        // R11: mid-frame input change only affects the next frame
        base_cfg(); apply();
        run_frame(1);
        b_vc = 2; b_hbp = 5;
        run_frame(0);

        // R1: non-video codes keep the stream idle
        for (int code = 3; code < 8; code++) begin
            base_cfg(); b_mode = code; apply();
            repeat (6) begin
                @(negedge clk); #1;
                chk(!tok_valid, "R1", "valid in non-video mode", int'(tok_valid), 0);
            end
        end
        base_cfg(); b_mode = 1; apply();
        run_frame(0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule